// File: doc/BRIEF.md
# OSD Pixel Color and Flash Stage

This stage sits at the end of an on-screen display pipeline. Every pixel clock it takes one glyph bit from the font path and the active color selection (a bank bit that holds for the whole row and a 3-bit index), and it emits the red, green and blue overlay bits together with the fast-blank line. The fast-blank line tells the video mixer to replace the picture with the overlay. A 16-byte color table, split into two banks of eight, supplies a foreground color, a background color, a transparent-background flag and a flash flag for each entry.

Several global settings shape the result. A flash-rate field blinks flagged foregrounds at one of three rates, timed from a counter of vertical-sync edges. A force-blank bit holds fast-blank high everywhere. A master enable clears all outputs. When lock gating is enabled, the outputs stay cleared until the pixel-clock PLL reports lock. A strip-level display enable blanks a whole row of text.

Top module: `osd_pixel_color`

## Requirements
- R1: After reset, table entry k (address {bank_sel, col_idx}, k = 0..7) holds {k, 7-k} as two hex nibbles in bank 0 and {7-k, k} in bank 1, so that bank 0 reads 07,16,...,70.
- R2: A table byte is read as bit 7 = transparent background, bits 6:4 = background R,G,B, bit 3 = flash enable, bits 2:0 = foreground R,G,B. A displayed pixel with pix_on=1 emits the foreground bits with fblk_out=1. With pix_on=0 and bit 7 clear, it emits the background bits with fblk_out=1.
- R3: The table byte used is the one at address {bank_sel, col_idx}.
- R4: A write with clut_we=1 stores clut_wdata at clut_waddr. Pixels driven after that clock edge use the new byte.
- R5: A background pixel (pix_on=0 or flashed off) whose byte has bit 7 set emits RGB=0 and fblk_out equal to force_blank.
- R6: With flash_mode=00, the flash bit has no effect and the foreground is always shown.
- R7: A field counter counts rising edges of vsync modulo 128. When the flash bit is set, the foreground is replaced by the background while counter bit 6 is 1 (mode 01), bit 5 is 1 (mode 10) or bit 4 is 1 (mode 11).
- R8: With osd_on=0, all four outputs are 0.
- R9: With force_blank=1, fblk_out is 1 inside and outside the active area. Outside the area (in_area=0), RGB is 0 and fblk_out equals force_blank.
- R10: Inside the area with strip_de=0, RGB is 0 and fblk_out equals force_blank.
- R11: With lock_en=1 and pll_locked=0, all outputs are 0. With lock_en=0, the lock input has no effect.
- R12: Outputs are registered: each reflects the inputs of the previous clock edge, and all outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clut_we | input | 1 | Color table write strobe |
| clut_waddr | input | 4 | Table write address {bank, index} |
| clut_wdata | input | 8 | Table write byte |
| osd_on | input | 1 | Master overlay enable |
| force_blank | input | 1 | Hold fast-blank high |
| flash_mode | input | 2 | Flash rate select |
| lock_en | input | 1 | Gate outputs on PLL lock |
| pll_locked | input | 1 | PLL lock status |
| vsync | input | 1 | Vertical sync, counted on rising edges |
| in_area | input | 1 | Pixel lies in the overlay area |
| strip_de | input | 1 | Current strip display enable |
| bank_sel | input | 1 | Color bank for this row |
| col_idx | input | 3 | Active color index within the bank |
| pix_on | input | 1 | Glyph pixel bit |
| r_out | output | 1 | Red overlay output |
| g_out | output | 1 | Green overlay output |
| b_out | output | 1 | Blue overlay output |
| fblk_out | output | 1 | Fast-blank output |

## Verification
The hardest case to reach is the off half of the flash cycle at each rate. It only occurs after tens of field edges, and it depends on one counter bit per mode. The stimulus pulses vsync in groups of sixteen, across more than one full wrap of the 128-field counter. After each group it samples a flagged entry under all four flash modes, so every rate is seen in both halves and across the wrap. The transparent and flash attributes are absent from the reset table, so they are reached by writing a new byte and then driving background pixels both with and without force-blank.

// File: rtl/osd_color_pkg.sv
// Package: shared types and reset-value helper for the OSD color stage.
// Assumes table entries are 8 bits in the fixed attribute layout below.
package osd_color_pkg;

    // One color-table byte, MSB first.
    typedef struct packed {
        logic       transp;
        logic [2:0] bg;
        logic       flash;
        logic [2:0] fg;
    } clut_entry_t;

    typedef enum logic [1:0] {
        FLASH_NONE = 2'b00,
        FLASH_X1   = 2'b01,
        FLASH_X2   = 2'b10,
        FLASH_X4   = 2'b11
    } flash_mode_e;

    // Reset byte for table slot idx: even banks ascend, odd banks mirror.
    function automatic logic [7:0] clut_reset_value(int unsigned idx, int unsigned per_bank);
        int unsigned k;
        int unsigned bank;
        logic [3:0]  hi;
        logic [3:0]  lo;
        k    = idx % per_bank;
        bank = idx / per_bank;
        hi   = 4'(k);
        lo   = 4'(per_bank - 1 - k);
        return (bank % 2 == 0) ? {hi, lo} : {lo, hi};
    endfunction

endpackage

// File: rtl/osd_clut.sv
// Module: banked color table with one synchronous write port and one
// combinational read port. Assumes the address is {bank, index}.
module osd_clut
    import osd_color_pkg::*;
#(
    parameter int BANKS    = 2,
    parameter int PER_BANK = 8,
    localparam int DEPTH   = BANKS * PER_BANK,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output clut_entry_t   rentry
);

    logic [7:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // Hold one table byte; reload its preset on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= clut_reset_value(i, PER_BANK);
            else if (we && (waddr == AW'(i)))
                mem[i] <= wdata;
        end
    end

    // Present the selected byte as an attribute struct.
    always_comb rentry = clut_entry_t'(mem[raddr]);

endmodule

// File: rtl/osd_flash_timer.sv
// Module: counts vsync rising edges modulo 2**FIELD_BITS and reports the
// off half of the selected flash rate. Assumes FIELD_BITS >= 3.
module osd_flash_timer
    import osd_color_pkg::*;
#(
    parameter int FIELD_BITS = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vsync,
    input  flash_mode_e mode,
    output logic        off_phase
);

    logic                  vs_q;
    logic [FIELD_BITS-1:0] field_cnt;

    // Detect vsync rising edges and advance the field counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q      <= 1'b0;
            field_cnt <= '0;
        end else begin
            vs_q <= vsync;
            if (vsync && !vs_q)
                field_cnt <= field_cnt + 1'b1;
        end
    end

    // Pick the counter bit whose high half is the flash-off window.
    always_comb begin
        case (mode)
            FLASH_X1: off_phase = field_cnt[FIELD_BITS-1];
            FLASH_X2: off_phase = field_cnt[FIELD_BITS-2];
            FLASH_X4: off_phase = field_cnt[FIELD_BITS-3];
            default:  off_phase = 1'b0;
        endcase
    end

endmodule

// File: rtl/osd_pixel_mux.sv
// Module: combinational pixel decision. Applies gating, area, strip,
// flash and transparency rules to one table entry. No state.
module osd_pixel_mux
    import osd_color_pkg::*;
(
    input  clut_entry_t ent,
    input  logic        pix_on,
    input  logic        off_phase,
    input  logic        osd_on,
    input  logic        force_blank,
    input  logic        lock_en,
    input  logic        pll_locked,
    input  logic        in_area,
    input  logic        strip_de,
    output logic [2:0]  rgb_nxt,
    output logic        fblk_nxt
);

    logic gated;
    logic show_fg;

    // Decide the next RGB and fast-blank value for this pixel.
    always_comb begin
        gated    = !osd_on || (lock_en && !pll_locked);
        show_fg  = pix_on && !(ent.flash && off_phase);
        rgb_nxt  = 3'b000;
        fblk_nxt = force_blank;
        if (gated) begin
            fblk_nxt = 1'b0;
        end else if (in_area && strip_de) begin
            if (show_fg) begin
                rgb_nxt  = ent.fg;
                fblk_nxt = 1'b1;
            end else if (!ent.transp) begin
                rgb_nxt  = ent.bg;
                fblk_nxt = 1'b1;
            end
        end
    end

endmodule

// File: rtl/osd_pixel_color.sv
// Module: top of the OSD pixel color and flash stage. Registers the RGB
// and fast-blank outputs one cycle after the pixel inputs.
// Assumes bank_sel is held constant for a row by the upstream logic.
module osd_pixel_color
    import osd_color_pkg::*;
#(
    parameter int BANKS      = 2,
    parameter int PER_BANK   = 8,
    parameter int FIELD_BITS = 7
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clut_we,
    input  logic [$clog2(BANKS*PER_BANK)-1:0]   clut_waddr,
    input  logic [7:0]                          clut_wdata,
    input  logic                                osd_on,
    input  logic                                force_blank,
    input  logic [1:0]                          flash_mode,
    input  logic                                lock_en,
    input  logic                                pll_locked,
    input  logic                                vsync,
    input  logic                                in_area,
    input  logic                                strip_de,
    input  logic [$clog2(BANKS)-1:0]            bank_sel,
    input  logic [$clog2(PER_BANK)-1:0]         col_idx,
    input  logic                                pix_on,
    output logic                                r_out,
    output logic                                g_out,
    output logic                                b_out,
    output logic                                fblk_out
);

    clut_entry_t ent;
    logic        off_phase;
    logic [2:0]  rgb_nxt;
    logic        fblk_nxt;

    osd_clut #(.BANKS(BANKS), .PER_BANK(PER_BANK)) u_clut (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (clut_we),
        .waddr  (clut_waddr),
        .wdata  (clut_wdata),
        .raddr  ({bank_sel, col_idx}),
        .rentry (ent)
    );

    osd_flash_timer #(.FIELD_BITS(FIELD_BITS)) u_flash (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync     (vsync),
        .mode      (flash_mode_e'(flash_mode)),
        .off_phase (off_phase)
    );

    osd_pixel_mux u_mux (
        .ent         (ent),
        .pix_on      (pix_on),
        .off_phase   (off_phase),
        .osd_on      (osd_on),
        .force_blank (force_blank),
        .lock_en     (lock_en),
        .pll_locked  (pll_locked),
        .in_area     (in_area),
        .strip_de    (strip_de),
        .rgb_nxt     (rgb_nxt),
        .fblk_nxt    (fblk_nxt)
    );

    // Register the pixel result toward the video mixer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {r_out, g_out, b_out} <= 3'b000;
            fblk_out              <= 1'b0;
        end else begin
            {r_out, g_out, b_out} <= rgb_nxt;
            fblk_out              <= fblk_nxt;
        end
    end

endmodule

// File: rtl/osd_pixel_color_chk.sv
// Module: port-level assertions for osd_pixel_color, attached by bind.
// Assumes the one-cycle output latency of the top module.
module osd_pixel_color_chk (
    input logic clk,
    input logic rst_n,
    input logic osd_on,
    input logic force_blank,
    input logic lock_en,
    input logic pll_locked,
    input logic in_area,
    input logic strip_de,
    input logic r_out,
    input logic g_out,
    input logic b_out,
    input logic fblk_out
);

    p_osd_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !osd_on |=> !r_out && !g_out && !b_out && !fblk_out);

    p_lock_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lock_en && !pll_locked |=> !r_out && !g_out && !b_out && !fblk_out);

    p_force_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        osd_on && force_blank && !(lock_en && !pll_locked) |=> fblk_out);

    p_outside_area_r9: assert property (@(posedge clk) disable iff (!rst_n)
        osd_on && !(lock_en && !pll_locked) && !in_area
        |=> !r_out && !g_out && !b_out && (fblk_out == $past(force_blank)));

    p_strip_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        osd_on && !(lock_en && !pll_locked) && in_area && !strip_de
        |=> !r_out && !g_out && !b_out && (fblk_out == $past(force_blank)));

endmodule

bind osd_pixel_color osd_pixel_color_chk u_chk (.*);

// File: tb/osd_pixel_color_tb.sv
// Bench: scoreboard. Driver tasks push expected outputs into a queue;
// a monitor pops one item per cycle after the clock edge and compares.
module osd_pixel_color_tb;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clut_we = 1'b0;
    logic [3:0] clut_waddr = '0;
    logic [7:0] clut_wdata = '0;
    logic       osd_on = 1'b0;
    logic       force_blank = 1'b0;
    logic [1:0] flash_mode = 2'b00;
    logic       lock_en = 1'b0;
    logic       pll_locked = 1'b0;
    logic       vsync = 1'b0;
    logic       in_area = 1'b0;
    logic       strip_de = 1'b0;
    logic       bank_sel = 1'b0;
    logic [2:0] col_idx = '0;
    logic       pix_on = 1'b0;
    logic       r_out, g_out, b_out, fblk_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] mt [16];
    logic [6:0] fld = '0;
    item_t      q[$];

    always #2 clk = ~clk;

    osd_pixel_color u_dut (
        .clk(clk), .rst_n(rst_n), .clut_we(clut_we), .clut_waddr(clut_waddr),
        .clut_wdata(clut_wdata), .osd_on(osd_on), .force_blank(force_blank),
        .flash_mode(flash_mode), .lock_en(lock_en), .pll_locked(pll_locked),
        .vsync(vsync), .in_area(in_area), .strip_de(strip_de),
        .bank_sel(bank_sel), .col_idx(col_idx), .pix_on(pix_on),
        .r_out(r_out), .g_out(g_out), .b_out(b_out), .fblk_out(fblk_out)
    );

    // Expected {r,g,b,fblk} from the requirements and bench settings.
    function automatic logic [3:0] model(logic pon, logic bk, logic [2:0] idx);
        logic [7:0] e;
        logic       off;
        e = mt[{bk, idx}];
        if (!osd_on || (lock_en && !pll_locked)) return 4'b0000;
        if (!in_area || !strip_de) return {3'b000, force_blank};
        case (flash_mode)
            2'b01:   off = fld[6];
            2'b10:   off = fld[5];
            2'b11:   off = fld[4];
            default: off = 1'b0;
        endcase
        if (pon && !(e[3] && off)) return {e[2:0], 1'b1};
        if (e[7]) return {3'b000, force_blank};
        return {e[6:4], 1'b1};
    endfunction

    task automatic check(logic [3:0] act, logic [3:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive one pixel at a falling edge and queue its expected output.
    task automatic drv(logic pon, logic bk, logic [2:0] idx, string tag);
        item_t it;
        pix_on   = pon;
        bank_sel = bk;
        col_idx  = idx;
        it.exp   = model(pon, bk, idx);
        it.tag   = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        clut_we = 1'b1; clut_waddr = a; clut_wdata = d;
        @(negedge clk);
        clut_we = 1'b0;
        mt[a] = d;
    endtask

    task automatic pulse_vs();
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
        @(negedge clk);
        fld = fld + 1'b1;
    endtask

    // Monitor: compare registered outputs just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check({r_out, g_out, b_out, fblk_out}, it.exp, it.tag);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) begin
            mt[k]     = {4'(k), 4'(7 - k)};
            mt[k + 8] = {4'(7 - k), 4'(k)};
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check({r_out, g_out, b_out, fblk_out}, 4'b0000, "R12 reset");

        // R1 R2 R3: every reset entry, foreground and background.
        osd_on = 1'b1; in_area = 1'b1; strip_de = 1'b1;
        for (int a = 0; a < 16; a++) begin
            drv(1'b1, a[3], a[2:0], "R1 R2 R3 fg");
            drv(1'b0, a[3], a[2:0], "R1 R2 R3 bg");
        end

        // R4 R5: rewrite an entry with transparent and flash set.
        wr(4'd5, 8'hC9);
        drv(1'b1, 1'b0, 3'd5, "R4 fg after write");
        drv(1'b0, 1'b0, 3'd5, "R5 transparent bg");
        force_blank = 1'b1;
        drv(1'b0, 1'b0, 3'd5, "R5 transparent bg forced");

        // R9: forced blank inside and outside area.
        drv(1'b1, 1'b1, 3'd2, "R9 forced inside");
        in_area = 1'b0;
        drv(1'b1, 1'b1, 3'd2, "R9 forced outside");
        force_blank = 1'b0;
        drv(1'b1, 1'b1, 3'd2, "R9 outside not forced");
        in_area = 1'b1;

        // R10: strip disabled, with and without force-blank.
        strip_de = 1'b0;
        drv(1'b1, 1'b0, 3'd3, "R10 strip off");
        force_blank = 1'b1;
        drv(1'b1, 1'b0, 3'd3, "R10 strip off forced");
        force_blank = 1'b0; strip_de = 1'b1;

        // R8: master enable off.
        osd_on = 1'b0;
        drv(1'b1, 1'b0, 3'd7, "R8 osd off");
        force_blank = 1'b1;
        drv(1'b0, 1'b0, 3'd7, "R8 osd off forced");
        force_blank = 1'b0; osd_on = 1'b1;

        // R11: lock gating.
        lock_en = 1'b1; pll_locked = 1'b0;
        drv(1'b1, 1'b0, 3'd1, "R11 unlocked gated");
        pll_locked = 1'b1;
        drv(1'b1, 1'b0, 3'd1, "R11 locked passes");
        lock_en = 1'b0; pll_locked = 1'b0;
        drv(1'b1, 1'b0, 3'd1, "R11 gate disabled");

        // R6 R7: flash sweep across more than one counter wrap.
        wr(4'd9, 8'h3D);
        for (int s = 0; s < 10; s++) begin
            for (int m = 0; m < 4; m++) begin
                flash_mode = 2'(m);
                drv(1'b1, 1'b1, 3'd1, (m == 0) ? "R6 flash ignored" : "R7 flash rate");
            end
            drv(1'b1, 1'b1, 3'd2, "R7 no flash bit");
            for (int p = 0; p < 16; p++) pulse_vs();
        end

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule